// File: doc/BRIEF.md
# Disk Interface Status Register

This block is the read-only status port of a floppy-style disk controller. It watches the controller's own drive-side outputs (two motor enables, write gate, two drive selects) and the asynchronous disk-side signals (read data, write data and an active-low drive-2 indication). It shows them to the host as one 8-bit value. The host bus decoder and the drive logic sit outside; this block supplies only the read value and takes one strobe that marks a host read of the separate digital input register.

A mode input chooses between two layouts. In the standard layout the host sees motor and write-gate levels, a mirror of drive select 0, two constant ones and two bits that change state on every falling edge of read data and of write data. In the compatibility layout the host sees three sticky flags, for a write-gate rise and for read-data and write-data falls, along with active-low drive selects, the synchronized drive-2 input and two constant ones. The sticky flags stay set until the digital-input-register read strobe arrives. A hardware reset clears everything. A software reset clears only the toggle and sticky state.

Top module: `disk_status_reg`

## Requirements
- R1: While rst_ni is low, rd_data_o reads 8'hC0 with mode_compat_i=0 and 8'hE3 with mode_compat_i=1 (drive selects low, drv2_ni high).
- R2: In standard mode (mode_compat_i=0), bits 1:0 give mot_en_i[1:0], bit 2 gives wgate_i and bit 5 gives ds_i[0], each one clock after the input. Bits 7:6 read 2'b11.
- R3: In standard mode, bit 3 changes state once for each falling edge of rdata_i. A rising edge leaves it unchanged. The change appears by the third rising clock edge after the input falls.
- R4: In standard mode, bit 4 changes state once for each falling edge of wdata_i. A rising edge leaves it unchanged, and bit 3 is not affected.
- R5: In compatibility mode (mode_compat_i=1), bit 2 is a sticky flag that a rising edge of wgate_i sets. A falling edge of wgate_i does not set it.
- R6: In compatibility mode, bit 3 is a sticky flag that a falling edge of rdata_i sets. Bit 4 is a sticky flag that a falling edge of wdata_i sets whether wgate_i is high or low.
- R7: A one-cycle pulse on dir_rd_i clears the three sticky flags. A flag whose setting edge falls in the same cycle as the pulse stays set.
- R8: In compatibility mode, bits 1:0 read 2'b11, bit 5 reads the inverse of ds_i[0], bit 6 reads the inverse of ds_i[1] and bit 7 reads the synchronized drv2_ni.
- R9: A one-cycle soft_rst_i clears both toggle bits and all sticky flags. The motor-enable and drive-select mirrors keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | Synchronous software reset of the toggle and sticky state |
| mode_compat_i | input | 1 | 0 selects the standard layout, 1 selects the compatibility layout |
| mot_en_i | input | 2 | Motor enable outputs for drives 1 and 0 |
| wgate_i | input | 1 | Write gate output, active high |
| ds_i | input | 2 | Drive select 1 and 0 outputs, active high |
| rdata_i | input | 1 | Read data from the disk, asynchronous |
| wdata_i | input | 1 | Write data to the disk, asynchronous |
| drv2_ni | input | 1 | Active-low drive-2 indication, asynchronous |
| dir_rd_i | input | 1 | One-cycle strobe for a host read of the digital input register |
| rd_data_o | output | 8 | Status value presented to the host |

## Verification
A read-data fall can set its sticky flag in the same cycle that a digital-input-register read clears the flags. The bench provokes this by timing the read strobe to the cycle in which the synchronized fall is detected, which is the cycle between the second and third clock edges after the input drops. It judges the result by reading the compatibility layout afterwards: the read-data flag must still be set and the write-gate and write-data flags must be cleared. A second collision, software reset against live toggle and sticky state, is judged by reading both layouts before and after the pulse.

// File: rtl/disk_stat_pkg.sv
package disk_stat_pkg;
  localparam int unsigned STAT_W = 8;

  typedef struct packed {
    logic mot1;
    logic mot0;
    logic wg;
    logic ds1;
    logic ds0;
  } ctl_lvl_t;

  typedef struct packed {
    logic rd_tog;
    logic wd_tog;
    logic wg_stk;
    logic rd_stk;
    logic wd_stk;
  } flag_t;
endpackage

// File: rtl/disk_sync.sv
module disk_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/disk_edge_track.sv
module disk_edge_track
  import disk_stat_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  soft_rst_i,
  input  logic  rd_s_i,
  input  logic  wd_s_i,
  input  logic  wg_i,
  input  logic  dir_rd_i,
  output flag_t flags_o
);
  logic rd_prev_q, wd_prev_q, wg_prev_q;
  logic rd_fall, wd_fall, wg_rise;
  flag_t flg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_prev_q <= 1'b0;
      wd_prev_q <= 1'b0;
      wg_prev_q <= 1'b0;
    end else begin
      rd_prev_q <= rd_s_i;
      wd_prev_q <= wd_s_i;
      wg_prev_q <= wg_i;
    end
  end

  assign rd_fall = rd_prev_q & ~rd_s_i;
  assign wd_fall = wd_prev_q & ~wd_s_i;
  assign wg_rise = ~wg_prev_q & wg_i;

  // priority: soft reset, then setting edge, then read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
    end else if (soft_rst_i) begin
      flg_q <= '0;
    end else begin
      flg_q.rd_tog <= flg_q.rd_tog ^ rd_fall;
      flg_q.wd_tog <= flg_q.wd_tog ^ wd_fall;
      flg_q.wg_stk <= wg_rise | (flg_q.wg_stk & ~dir_rd_i);
      flg_q.rd_stk <= rd_fall | (flg_q.rd_stk & ~dir_rd_i);
      flg_q.wd_stk <= wd_fall | (flg_q.wd_stk & ~dir_rd_i);
    end
  end

  assign flags_o = flg_q;

  p_rd_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fall && !soft_rst_i) |=> (flg_q.rd_tog != $past(flg_q.rd_tog)));
  p_rd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_fall && !soft_rst_i) |=> $stable(flg_q.rd_tog));
  p_wd_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_fall && !soft_rst_i) |=> (flg_q.wd_tog != $past(flg_q.wd_tog)));
  p_wg_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wg_rise && !soft_rst_i) |=> flg_q.wg_stk);
  p_rdwd_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fall && wd_fall && !soft_rst_i) |=> (flg_q.rd_stk && flg_q.wd_stk));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rd_i && !wg_rise && !rd_fall && !wd_fall) |=>
    !(flg_q.wg_stk || flg_q.rd_stk || flg_q.wd_stk));
  p_soft_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (flg_q == '0));
endmodule

// File: rtl/disk_status_mux.sv
module disk_status_mux
  import disk_stat_pkg::*;
(
  input  logic              mode_compat_i,
  input  ctl_lvl_t          lvl_i,
  input  flag_t             flags_i,
  input  logic              drv2_n_s_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] std_val, cmp_val;

  always_comb begin
    std_val = {2'b11, lvl_i.ds0, flags_i.wd_tog, flags_i.rd_tog,
               lvl_i.wg, lvl_i.mot1, lvl_i.mot0};
    cmp_val = {drv2_n_s_i, ~lvl_i.ds1, ~lvl_i.ds0, flags_i.wd_stk,
               flags_i.rd_stk, flags_i.wg_stk, 2'b11};
    stat_o  = mode_compat_i ? cmp_val : std_val;
  end
endmodule

// File: rtl/disk_status_reg.sv
module disk_status_reg
  import disk_stat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        soft_rst_i,
  input  logic        mode_compat_i,
  input  logic [1:0]  mot_en_i,
  input  logic        wgate_i,
  input  logic [1:0]  ds_i,
  input  logic        rdata_i,
  input  logic        wdata_i,
  input  logic        drv2_ni,
  input  logic        dir_rd_i,
  output logic [7:0]  rd_data_o
);
  ctl_lvl_t   lvl_q;
  flag_t      flags;
  logic [1:0] data_s;
  logic       drv2_n_s;

  // mirrors: hardware reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= '{mot1: mot_en_i[1], mot0: mot_en_i[0], wg: wgate_i,
                            ds1: ds_i[1], ds0: ds_i[0]};
  end

  disk_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_data_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i({rdata_i, wdata_i}), .q_o(data_s)
  );

  disk_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_drv2_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(drv2_ni), .q_o(drv2_n_s)
  );

  disk_edge_track u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .rd_s_i    (data_s[1]),
    .wd_s_i    (data_s[0]),
    .wg_i      (lvl_q.wg),
    .dir_rd_i  (dir_rd_i),
    .flags_o   (flags)
  );

  disk_status_mux u_mux (
    .mode_compat_i(mode_compat_i),
    .lvl_i        (lvl_q),
    .flags_i      (flags),
    .drv2_n_s_i   (drv2_n_s),
    .stat_o       (rd_data_o)
  );

  p_std_motor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_compat_i && $past(rst_ni)) |-> (rd_data_o[1:0] == $past(mot_en_i)));
  p_cmp_ds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_compat_i && $past(rst_ni)) |-> (rd_data_o[6:5] == ~$past(ds_i)));
  p_soft_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && $stable(mot_en_i)) |=> (lvl_q.mot1 == $past(mot_en_i[1])));
endmodule

// File: tb/disk_status_reg_tb.sv
module disk_status_reg_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       mode_compat_i = 1'b0;
  logic [1:0] mot_en_i = 2'b00;
  logic       wgate_i = 1'b0;
  logic [1:0] ds_i = 2'b00;
  logic       rdata_i = 1'b0;
  logic       wdata_i = 1'b0;
  logic       drv2_ni = 1'b1;
  logic       dir_rd_i = 1'b0;
  logic [7:0] rd_data_o;

  int errors = 0;
  int checks = 0;

  always #4ns clk_i = ~clk_i;

  disk_status_reg u_dut (.*);

  // {mode, mot[1:0], ds[1:0], drv2_n, expected[7:0]}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 2'b01, 2'b00, 1'b1, 8'hC1},
    {1'b0, 2'b10, 2'b01, 1'b1, 8'hE2},
    {1'b0, 2'b11, 2'b11, 1'b1, 8'hE3},
    {1'b1, 2'b11, 2'b00, 1'b1, 8'hE3},
    {1'b1, 2'b00, 2'b01, 1'b1, 8'hC3},
    {1'b1, 2'b00, 2'b10, 1'b0, 8'h23},
    {1'b1, 2'b01, 2'b11, 1'b0, 8'h03},
    {1'b0, 2'b00, 2'b00, 1'b0, 8'hC0}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_rd();
    rdata_i = 1'b1; wait_n(4);
    rdata_i = 1'b0; wait_n(4);
  endtask

  task automatic pulse_wd();
    wdata_i = 1'b1; wait_n(4);
    wdata_i = 1'b0; wait_n(4);
  endtask

  task automatic dir_read();
    @(negedge clk_i) dir_rd_i = 1'b1;
    @(negedge clk_i) dir_rd_i = 1'b0;
  endtask

  initial begin
    wait_n(3);
    chk("R1 reset std", rd_data_o, 8'hC0);
    mode_compat_i = 1'b1; #1ns;
    chk("R1 reset compat", rd_data_o, 8'hE3);
    mode_compat_i = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < 8; i++) begin
      mode_compat_i = VEC[i][13];
      mot_en_i      = VEC[i][12:11];
      ds_i          = VEC[i][10:9];
      drv2_ni       = VEC[i][8];
      wait_n(4);
      chk($sformatf("R2/R8 vector %0d", i), rd_data_o, VEC[i][7:0]);
    end

    mode_compat_i = 1'b0; mot_en_i = 2'b00; ds_i = 2'b00; drv2_ni = 1'b1;
    wait_n(4);
    rdata_i = 1'b1; wait_n(4);
    chk("R3 rise no toggle", {7'd0, rd_data_o[3]}, 8'd0);
    rdata_i = 1'b0; wait_n(4);
    chk("R3 first fall", {7'd0, rd_data_o[3]}, 8'd1);
    pulse_rd();
    chk("R3 second fall", {7'd0, rd_data_o[3]}, 8'd0);

    wdata_i = 1'b1; wait_n(4);
    chk("R4 rise no toggle", {6'd0, rd_data_o[4:3]}, 8'd0);
    wdata_i = 1'b0; wait_n(4);
    chk("R4 first fall, bit3 kept", {6'd0, rd_data_o[4:3]}, 8'b10);
    pulse_wd();
    chk("R4 second fall", {7'd0, rd_data_o[4]}, 8'd0);

    wgate_i = 1'b1; wait_n(4);
    chk("R2 write gate level", rd_data_o, 8'hC4);
    mode_compat_i = 1'b1; #1ns;
    chk("R5 R6 sticky flags set", {5'd0, rd_data_o[4:2]}, 8'b111);
    dir_read();
    chk("R7 read clears flags", {5'd0, rd_data_o[4:2]}, 8'b000);
    wgate_i = 1'b0; wait_n(4);
    chk("R5 gate fall no set", {5'd0, rd_data_o[4:2]}, 8'b000);

    pulse_wd();
    rdata_i = 1'b1; wait_n(4);
    @(negedge clk_i) rdata_i = 1'b0;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i) dir_rd_i = 1'b1;
    @(negedge clk_i) dir_rd_i = 1'b0;
    chk("R7 set wins over clear", {5'd0, rd_data_o[4:2]}, 8'b010);

    mode_compat_i = 1'b0; mot_en_i = 2'b11; ds_i = 2'b01;
    wait_n(4);
    chk("R9 std before soft", rd_data_o, 8'hFB);
    mode_compat_i = 1'b1; #1ns;
    chk("R9 compat before soft", rd_data_o, 8'hCB);
    @(negedge clk_i) soft_rst_i = 1'b1;
    @(negedge clk_i) soft_rst_i = 1'b0;
    chk("R9 compat after soft", rd_data_o, 8'hC3);
    mode_compat_i = 1'b0; #1ns;
    chk("R9 std after soft", rd_data_o, 8'hE3);

    @(negedge clk_i) rst_ni = 1'b0;
    #1ns;
    chk("R1 hw reset mid-run", rd_data_o, 8'hC0);
    @(negedge clk_i) rst_ni = 1'b1;
    wait_n(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule